// File: doc/BRIEF.md
# Processor Bus to Endpoint FIFO Bridge

This block is the glue between the external memory bus of a 16-bit signal processor and the synchronous slave FIFO port of a USB controller. The processor acts as bus master: it puts a page address and a read/write level on the bus, and the bridge turns them into the strobes the FIFO port needs. The bridge also holds the processor in a wait state whenever the selected FIFO cannot supply or take a word.

The FIFO port accepts a slower clock than the processor bus runs at, so the bridge halves the bus clock and drives that to the FIFO port. Three pages of the upper address byte are decoded. Two pages read from the host-to-device (OUT) endpoint. One page writes to the device-to-host (IN) endpoint. The 16-bit data words pass straight through in both directions. Chip select is tied active. The packet-commit line follows a general-purpose flag output of the processor.

Top module: `busFifoBridge`

## Requirements
- R1: `ifClk` is low during reset. After reset is released, `ifClk` toggles on every rising edge of `busClk`, so its frequency is exactly half the bus clock.
- R2: An upper address byte of 0x10 or 0x11 is a read page for the OUT endpoint and drives `fifoAddr` to 2'b00.
- R3: An upper address byte of 0x12 drives `fifoAddr` to 2'b01 (IN endpoint). `fifoAddr` is 2'b00 for every other address.
- R4: `fifoOeN` is low only when `pageSelN` is low, `busRdWr` is high (read) and the address is a read page.
- R5: `fifoWrN` is low only when `pageSelN` is low, `busRdWr` is low (write) and the address is the write page.
- R6: `fifoRdN` is low exactly when `fifoOeN` is low and `ifClk` is high.
- R7: `dspReadyN` is high (wait) when a read is enabled and `emptyFlag` is high, or when a write is enabled and `fullFlag` is high. Otherwise it is low (proceed).
- R8: When `pageSelN` is high, or the address is none of 0x10, 0x11 or 0x12, then `fifoOeN`, `fifoWrN` and `fifoRdN` are all high, `dspReadyN` is low, and `fullFlag` and `emptyFlag` have no effect.
- R9: `fifoCsN` is always low, and `fifoPktEnd` equals `dspFlag`.
- R10: `fifoWrData` equals `dspWrData`, and `dspRdData` equals `fifoRdData`, on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Processor bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddrHi | input | 8 | Upper address byte (bits 15:8) of the bus |
| pageSelN | input | 1 | Active-low page select from the processor |
| busRdWr | input | 1 | Bus direction, 1 = read, 0 = write |
| dspFlag | input | 1 | General-purpose flag output of the processor |
| emptyFlag | input | 1 | OUT FIFO empty, active high |
| fullFlag | input | 1 | IN FIFO full, active high |
| dspWrData | input | 16 | Write data from the processor |
| fifoRdData | input | 16 | Read data from the FIFO port |
| ifClk | output | 1 | FIFO interface clock, bus clock / 2 |
| fifoAddr | output | 2 | FIFO select code |
| fifoOeN | output | 1 | Active-low FIFO output enable |
| fifoRdN | output | 1 | Active-low FIFO read strobe |
| fifoWrN | output | 1 | Active-low FIFO write strobe |
| fifoCsN | output | 1 | Active-low FIFO chip select |
| fifoPktEnd | output | 1 | Packet commit to the FIFO port |
| dspReadyN | output | 1 | Active-low ready to the processor, high = wait |
| fifoWrData | output | 16 | Write data to the FIFO port |
| dspRdData | output | 16 | Read data to the processor |

## Verification
The assertions sample the combinational strobes on the rising edge of `busClk`. They therefore assume that address, page select, direction and the two flags are stable around that edge, as a synchronous bus master and a synchronous FIFO provide. The stimulus changes every input on the falling edge only. Each input combination is held for two bus cycles, so the read strobe is observed in both phases of the divided clock. Every pass sweeps all decoded and undecoded addresses against every page select, direction and flag setting.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int FIFO_ADDR_W = 2;
  localparam logic [FIFO_ADDR_W-1:0] SEL_OUT_EP = 2'b00;
  localparam logic [FIFO_ADDR_W-1:0] SEL_IN_EP  = 2'b01;

  typedef struct packed {
    logic                   rdSel;     // enabled read of the OUT endpoint
    logic                   wrSel;     // enabled write of the IN endpoint
    logic                   inWindow;  // page selected and address decoded
    logic [FIFO_ADDR_W-1:0] fifoAddr;  // endpoint select code
  } strobe_t;
endpackage

// File: rtl/bridgeDecode.sv
module bridgeDecode
  import bridge_pkg::*;
#(
  parameter int ADDR_HI_W = 8,
  parameter logic [ADDR_HI_W-1:0] RD_PAGE_A = 8'h10,
  parameter logic [ADDR_HI_W-1:0] RD_PAGE_B = 8'h11,
  parameter logic [ADDR_HI_W-1:0] WR_PAGE   = 8'h12
) (
  input  logic [ADDR_HI_W-1:0] addrHi,
  input  logic                 pageSelN,
  input  logic                 rdWr,
  output strobe_t              strb
);
  logic hitRead;
  logic hitWrite;
  logic pageOn;

  always_comb begin
    hitRead  = (addrHi == RD_PAGE_A) || (addrHi == RD_PAGE_B);
    hitWrite = (addrHi == WR_PAGE);
    pageOn   = ~pageSelN;

    strb.rdSel    = pageOn &  rdWr & hitRead;
    strb.wrSel    = pageOn & ~rdWr & hitWrite;
    strb.inWindow = pageOn & (hitRead | hitWrite);
    strb.fifoAddr = hitWrite ? SEL_IN_EP : SEL_OUT_EP;
  end
endmodule

// File: rtl/bridgeDatapath.sv
module bridgeDatapath
  import bridge_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                   busClk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic                   emptyFlag,
  input  logic                   fullFlag,
  input  logic                   dspFlag,
  input  logic [DATA_W-1:0]      dspWrData,
  input  logic [DATA_W-1:0]      fifoRdData,
  output logic                   ifClk,
  output logic [FIFO_ADDR_W-1:0] fifoAddr,
  output logic                   fifoOeN,
  output logic                   fifoRdN,
  output logic                   fifoWrN,
  output logic                   fifoCsN,
  output logic                   fifoPktEnd,
  output logic                   dspReadyN,
  output logic [DATA_W-1:0]      fifoWrData,
  output logic [DATA_W-1:0]      dspRdData
);
  logic halfClk;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) halfClk <= 1'b0;
    else       halfClk <= ~halfClk;
  end

  always_comb begin
    ifClk      = halfClk;
    fifoAddr   = strb.fifoAddr;
    fifoOeN    = ~strb.rdSel;
    fifoWrN    = ~strb.wrSel;
    fifoRdN    = ~(strb.rdSel & halfClk);
    fifoCsN    = 1'b0;
    fifoPktEnd = dspFlag;
    dspReadyN  = (strb.rdSel & emptyFlag) | (strb.wrSel & fullFlag);
    fifoWrData = dspWrData;
    dspRdData  = fifoRdData;
  end

  // R1
  ifclk_toggle_chk: assert property (@(posedge busClk) disable iff (!rstN)
    1'b1 |=> (ifClk != $past(ifClk)));

  // R6
  rd_needs_oe_chk: assert property (@(posedge busClk) disable iff (!rstN)
    !fifoRdN |-> !fifoOeN);

  // R4 R5
  strobe_excl_chk: assert property (@(posedge busClk) disable iff (!rstN)
    $onehot0({!fifoOeN, !fifoWrN}));

  // R7
  empty_wait_chk: assert property (@(posedge busClk) disable iff (!rstN)
    (!fifoOeN && emptyFlag) |-> dspReadyN);

  // R7
  full_wait_chk: assert property (@(posedge busClk) disable iff (!rstN)
    (!fifoWrN && fullFlag) |-> dspReadyN);

  // R8
  idle_quiet_chk: assert property (@(posedge busClk) disable iff (!rstN)
    !strb.inWindow |-> (fifoOeN && fifoWrN && fifoRdN && !dspReadyN));
endmodule

// File: rtl/busFifoBridge.sv
module busFifoBridge
  import bridge_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_HI_W = 8
) (
  input  logic                 busClk,
  input  logic                 rstN,
  input  logic [ADDR_HI_W-1:0] busAddrHi,
  input  logic                 pageSelN,
  input  logic                 busRdWr,
  input  logic                 dspFlag,
  input  logic                 emptyFlag,
  input  logic                 fullFlag,
  input  logic [DATA_W-1:0]    dspWrData,
  input  logic [DATA_W-1:0]    fifoRdData,
  output logic                 ifClk,
  output logic [1:0]           fifoAddr,
  output logic                 fifoOeN,
  output logic                 fifoRdN,
  output logic                 fifoWrN,
  output logic                 fifoCsN,
  output logic                 fifoPktEnd,
  output logic                 dspReadyN,
  output logic [DATA_W-1:0]    fifoWrData,
  output logic [DATA_W-1:0]    dspRdData
);
  strobe_t strb;

  bridgeDecode #(.ADDR_HI_W(ADDR_HI_W)) i_decode (
    .addrHi   (busAddrHi),
    .pageSelN (pageSelN),
    .rdWr     (busRdWr),
    .strb     (strb)
  );

  bridgeDatapath #(.DATA_W(DATA_W)) i_datapath (
    .busClk     (busClk),
    .rstN       (rstN),
    .strb       (strb),
    .emptyFlag  (emptyFlag),
    .fullFlag   (fullFlag),
    .dspFlag    (dspFlag),
    .dspWrData  (dspWrData),
    .fifoRdData (fifoRdData),
    .ifClk      (ifClk),
    .fifoAddr   (fifoAddr),
    .fifoOeN    (fifoOeN),
    .fifoRdN    (fifoRdN),
    .fifoWrN    (fifoWrN),
    .fifoCsN    (fifoCsN),
    .fifoPktEnd (fifoPktEnd),
    .dspReadyN  (dspReadyN),
    .fifoWrData (fifoWrData),
    .dspRdData  (dspRdData)
  );
endmodule

// File: tb/test_busFifoBridge.sv
module test_busFifoBridge;
  typedef struct {
    logic        ifClk;
    logic [1:0]  fifoAddr;
    logic        oeN;
    logic        rdN;
    logic        wrN;
    logic        readyN;
    logic        pktEnd;
    logic [15:0] wrData;
    logic [15:0] rdData;
  } expect_t;

  logic        busClk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddrHi = '0;
  logic        pageSelN = 1'b1;
  logic        busRdWr = 1'b1;
  logic        dspFlag = 1'b0;
  logic        emptyFlag = 1'b0;
  logic        fullFlag = 1'b0;
  logic [15:0] dspWrData = '0;
  logic [15:0] fifoRdData = '0;
  logic        ifClk, fifoOeN, fifoRdN, fifoWrN, fifoCsN, fifoPktEnd, dspReadyN;
  logic [1:0]  fifoAddr;
  logic [15:0] fifoWrData, dspRdData;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  int riseCnt = 0;
  bit finished = 0;
  expect_t expQ[$];
  event applied;

  always #4 busClk = ~busClk;

  busFifoBridge i_busFifoBridge (
    .busClk(busClk), .rstN(rstN), .busAddrHi(busAddrHi), .pageSelN(pageSelN),
    .busRdWr(busRdWr), .dspFlag(dspFlag), .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .dspWrData(dspWrData), .fifoRdData(fifoRdData), .ifClk(ifClk), .fifoAddr(fifoAddr),
    .fifoOeN(fifoOeN), .fifoRdN(fifoRdN), .fifoWrN(fifoWrN), .fifoCsN(fifoCsN),
    .fifoPktEnd(fifoPktEnd), .dspReadyN(dspReadyN), .fifoWrData(fifoWrData),
    .dspRdData(dspRdData)
  );

  always @(posedge busClk) if (rstN) edgeCnt <= edgeCnt + 1;
  always @(posedge ifClk) riseCnt <= riseCnt + 1;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: applies one bus state on a falling edge and queues what the requirements predict.
  task automatic applyCase(input logic [7:0] addr, input logic pg, input logic rw,
                           input logic full, input logic empty, input logic flag,
                           input logic [15:0] wd, input logic [15:0] rd);
    expect_t e;
    logic hitRd, hitWr, rdOn, wrOn, phase;
    @(negedge busClk);
    busAddrHi = addr; pageSelN = pg; busRdWr = rw; fullFlag = full;
    emptyFlag = empty; dspFlag = flag; dspWrData = wd; fifoRdData = rd;
    phase = rstN ? 1'((edgeCnt) & 1) : 1'b0;          // R1: toggles each bus edge
    hitRd = (addr == 8'h10) || (addr == 8'h11);         // R2
    hitWr = (addr == 8'h12);                            // R3
    rdOn  = !pg && rw && hitRd;                         // R4
    wrOn  = !pg && !rw && hitWr;                        // R5
    e.ifClk    = phase;
    e.fifoAddr = hitWr ? 2'b01 : 2'b00;
    e.oeN      = !rdOn;
    e.wrN      = !wrOn;
    e.rdN      = !(rdOn && phase);                      // R6
    e.readyN   = (rdOn && empty) || (wrOn && full);     // R7, R8
    e.pktEnd   = flag;                                  // R9
    e.wrData   = wd;                                    // R10
    e.rdData   = rd;
    expQ.push_back(e);
    ->applied;
  endtask

  // Monitor: pops expected items and compares them with the outputs between edges.
  initial begin
    forever begin
      @(applied);
      #1;
      while (expQ.size() > 0) begin
        expect_t e;
        e = expQ.pop_front();
        check("R1 ifClk", ifClk, e.ifClk);
        check("R2/R3 fifoAddr", fifoAddr, e.fifoAddr);
        check("R4 fifoOeN", fifoOeN, e.oeN);
        check("R5 fifoWrN", fifoWrN, e.wrN);
        check("R6 fifoRdN", fifoRdN, e.rdN);
        check("R7/R8 dspReadyN", dspReadyN, e.readyN);
        check("R9 fifoCsN", fifoCsN, 0);
        check("R9 fifoPktEnd", fifoPktEnd, e.pktEnd);
        check("R10 fifoWrData", fifoWrData, e.wrData);
        check("R10 dspRdData", dspRdData, e.rdData);
      end
    end
  end

  initial begin
    logic [7:0] addrs [6];
    int startRise;
    addrs[0] = 8'h10; addrs[1] = 8'h11; addrs[2] = 8'h12;
    addrs[3] = 8'h13; addrs[4] = 8'h00; addrs[5] = 8'hFF;

    // R1 reset state, strobes driven under reset
    repeat (3) applyCase(8'h10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1234, 16'hABCD);
    @(negedge busClk);
    rstN = 1'b1;

    for (int a = 0; a < 6; a++)
      for (int pg = 0; pg < 2; pg++)
        for (int rw = 0; rw < 2; rw++)
          for (int fu = 0; fu < 2; fu++)
            for (int em = 0; em < 2; em++)
              for (int ph = 0; ph < 2; ph++)
                applyCase(addrs[a], 1'(pg), 1'(rw), 1'(fu), 1'(em), 1'((a + ph) & 1),
                          16'(a * 4097 + pg * 257 + rw * 17 + fu * 3 + em + ph * 16'h8000),
                          16'(16'hFFFF - a * 911 - rw * 33 - em * 7 - ph));

    // R1 frequency: 40 bus edges give 20 rising edges of ifClk
    @(negedge busClk);
    startRise = riseCnt;
    repeat (40) @(posedge busClk);
    @(negedge busClk);
    check("R1 ifClk rising edges over 40 bus cycles", riseCnt - startRise, 20);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule